// File: doc/BRIEF.md
# Bank-to-region memory map decoder

This block decodes a 24-bit CPU access into one of the system memory regions. The CPU places the upper address byte (the bank) on the data bus early in each cycle. The decoder captures that byte and combines it with the 16-bit address. The possible regions are motherboard RAM, expansion RAM, slow RAM, expansion ROM, motherboard ROM and unmapped. For expansion RAM, the decoder also produces a 2-bit row select and a multiplexed row/column DRAM address.

Three strap inputs move the region boundaries:
- `big_board_i` sets the amount of motherboard RAM.
- `row_1m_i` sets the size of each expansion row.
- `rom_split_i` sets where the top ROM banks divide between the expansion slot and the motherboard.

During a DMA cycle the bank does not come from the bus. It comes from an internal DMA bank register, which is written from `data_i`, and it passes through the same map.

Top module: `bank_map_decoder`

## Requirements
- R1: At a rising clock edge where `bank_le_i`=1 and `dma_i`=0, the bus bank register loads `data_i`. The decode then uses that bank until the next such edge, whatever `data_i` does in between. Reset clears the bus bank and DMA bank registers to 0.
- R2: Motherboard RAM (region code 1) covers banks $00-$01 when `big_board_i`=0 and banks $00-$0F when `big_board_i`=1.
- R3: With `row_1m_i`=0, expansion RAM (region code 2, `exp_ram_sel_o`=1) covers four rows of 4 banks each. The rows start at base = $02 (small board) or $10 (large board). `row_sel_o` = (bank-base)/4.
- R4: With `row_1m_i`=1, expansion RAM covers four rows of 16 banks each, starting at the same base. `row_sel_o` = (bank-base)/16.
- R5: Banks $E0 and $E1 decode to slow RAM (region code 3).
- R6: With `rom_split_i`=0, banks $F0-$FB decode to expansion ROM (code 4) and $FC-$FF to motherboard ROM (code 5). With `rom_split_i`=1, expansion ROM is $F0-$FD and motherboard ROM is $FE-$FF.
- R7: Every other bank decodes to unmapped (code 0). For any region other than expansion RAM, `exp_ram_sel_o`, `row_sel_o` and `dram_addr_o` are all 0.
- R8: In 256 KB row mode, A = {off[1:0], addr_i}, which is 18 bits, where off = bank-base. `dram_addr_o` is {0, A[17:9]} while `mux_phase_i`=0 and {0, A[8:0]} while `mux_phase_i`=1.
- R9: In 1 MB row mode, A = {off[3:0], addr_i}, which is 20 bits. `dram_addr_o` is A[19:10] while `mux_phase_i`=0 and A[9:0] while `mux_phase_i`=1.
- R10: While `dma_i`=1, the decode uses the DMA bank register, and `bank_le_i` has no effect on the bus bank. That register loads `data_i` at a rising edge where `dma_bank_we_i`=1. When `dma_i` falls, the decode returns to the bus bank captured before the DMA cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Data bus carrying the bank byte, or the DMA bank write data |
| bank_le_i | input | 1 | Bank capture enable, asserted in the first half of a CPU cycle |
| addr_i | input | 16 | Low address from the CPU or from the DMA requester |
| dma_i | input | 1 | DMA cycle in progress |
| dma_bank_we_i | input | 1 | Write enable for the DMA bank register |
| big_board_i | input | 1 | 0: 2 banks of motherboard RAM, 1: 16 banks |
| row_1m_i | input | 1 | 0: 4 banks per expansion row, 1: 16 banks |
| rom_split_i | input | 1 | Top ROM split: 0 at $FC, 1 at $FE |
| mux_phase_i | input | 1 | 0 selects the row half, 1 the column half |
| region_o | output | 3 | Region code |
| exp_ram_sel_o | output | 1 | Expansion RAM selected |
| row_sel_o | output | 2 | Expansion row select |
| dram_addr_o | output | 10 | Multiplexed DRAM address |

## Verification
The bank registers are the only state in the block. A bank written with `bank_le_i` or `dma_bank_we_i` therefore shows up on every output just after the capturing rising edge. Changes to the address, the straps, `dma_i` and `mux_phase_i` reach the outputs within the same cycle, with no clock between.

The bench drives its inputs at the falling edge and checks one time unit after the next rising edge. To show that the captured value is held, it then scrambles `data_i` before checking. To check the column half within the same cycle, it toggles `mux_phase_i` and waits one time unit.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  localparam int unsigned BANK_W = 8;
  localparam int unsigned ADDR_W = 16;

  typedef enum logic [2:0] {
    REG_NONE     = 3'd0,
    REG_MB_RAM   = 3'd1,
    REG_EXP_RAM  = 3'd2,
    REG_SLOW_RAM = 3'd3,
    REG_EXP_ROM  = 3'd4,
    REG_MB_ROM   = 3'd5
  } region_e;
endpackage

// File: rtl/bmd_bank_src.sv
module bmd_bank_src #(
  parameter int unsigned BANK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] data_i,
  input  logic              bank_le_i,
  input  logic              dma_i,
  input  logic              dma_bank_we_i,
  output logic [BANK_W-1:0] bank_o
);
  logic [BANK_W-1:0] bus_bank_q, dma_bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_bank_q <= '0;
      dma_bank_q <= '0;
    end else begin
      if (bank_le_i && !dma_i) bus_bank_q <= data_i;
      if (dma_bank_we_i)       dma_bank_q <= data_i;
    end
  end

  assign bank_o = dma_i ? dma_bank_q : bus_bank_q;

  // R10
  dma_holds_bus_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_i |=> $stable(bus_bank_q));
endmodule

// File: rtl/bmd_region_dec.sv
module bmd_region_dec
  import bmd_pkg::*;
#(
  parameter int unsigned BANK_W          = 8,
  parameter int unsigned NUM_ROWS        = 4,
  parameter int unsigned SMALL_ROW_BANKS = 4,
  parameter int unsigned LARGE_ROW_BANKS = 16,
  parameter logic [BANK_W-1:0] MB_SMALL_TOP = 8'h01,
  parameter logic [BANK_W-1:0] MB_LARGE_TOP = 8'h0F,
  parameter logic [BANK_W-1:0] SLOW_LO      = 8'hE0,
  parameter logic [BANK_W-1:0] SLOW_HI      = 8'hE1,
  parameter logic [BANK_W-1:0] XROM_LO      = 8'hF0,
  parameter logic [BANK_W-1:0] SPLIT_LO     = 8'hFC,
  parameter logic [BANK_W-1:0] SPLIT_HI     = 8'hFE,
  localparam int unsigned ROW_W = $clog2(NUM_ROWS),
  localparam int unsigned LOG_S = $clog2(SMALL_ROW_BANKS),
  localparam int unsigned LOG_L = $clog2(LARGE_ROW_BANKS)
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic              big_board_i,
  input  logic              row_1m_i,
  input  logic              rom_split_i,
  output region_e           region_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [LOG_L-1:0]  off_o
);
  localparam logic [BANK_W:0] SPAN_S = (BANK_W+1)'(NUM_ROWS * SMALL_ROW_BANKS);
  localparam logic [BANK_W:0] SPAN_L = (BANK_W+1)'(NUM_ROWS * LARGE_ROW_BANKS);

  logic [BANK_W-1:0] mb_top, split;
  logic [BANK_W:0]   base, off_full, span;
  logic              exp_hit;

  always_comb begin
    mb_top   = big_board_i ? MB_LARGE_TOP : MB_SMALL_TOP;
    base     = {1'b0, mb_top} + 1'b1;
    // below base wraps to a large value, so one compare bounds both ends
    off_full = {1'b0, bank_i} - base;
    span     = row_1m_i ? SPAN_L : SPAN_S;
    exp_hit  = off_full < span;
    split    = rom_split_i ? SPLIT_HI : SPLIT_LO;

    region_o = REG_NONE;
    row_o    = '0;
    off_o    = '0;
    if (bank_i <= mb_top) begin
      region_o = REG_MB_RAM;
    end else if (exp_hit) begin
      region_o = REG_EXP_RAM;
      if (row_1m_i) begin
        row_o = off_full[LOG_L +: ROW_W];
        off_o = off_full[LOG_L-1:0];
      end else begin
        row_o = off_full[LOG_S +: ROW_W];
        off_o = {{(LOG_L-LOG_S){1'b0}}, off_full[LOG_S-1:0]};
      end
    end else if (bank_i >= SLOW_LO && bank_i <= SLOW_HI) begin
      region_o = REG_SLOW_RAM;
    end else if (bank_i >= split) begin
      region_o = REG_MB_ROM;
    end else if (bank_i >= XROM_LO) begin
      region_o = REG_EXP_ROM;
    end
  end
endmodule

// File: rtl/bmd_addr_mux.sv
module bmd_addr_mux #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LOG_S  = 2,
  parameter int unsigned LOG_L  = 4,
  localparam int unsigned S_W    = ADDR_W + LOG_S,
  localparam int unsigned L_W    = ADDR_W + LOG_L,
  localparam int unsigned S_HALF = S_W / 2,
  localparam int unsigned L_HALF = L_W / 2
) (
  input  logic [LOG_L-1:0]  off_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              row_1m_i,
  input  logic              phase_i,
  input  logic              en_i,
  output logic [L_HALF-1:0] dram_addr_o
);
  logic [L_W-1:0]    full;
  logic [L_HALF-1:0] row_half, col_half;

  always_comb begin
    // off_i upper bits are zero in small-row mode
    full = {off_i, addr_i};
    if (row_1m_i) begin
      row_half = full[L_W-1:L_HALF];
      col_half = full[L_HALF-1:0];
    end else begin
      row_half = {{(L_HALF-S_HALF){1'b0}}, full[S_W-1:S_HALF]};
      col_half = {{(L_HALF-S_HALF){1'b0}}, full[S_HALF-1:0]};
    end
    dram_addr_o = !en_i ? '0 : (phase_i ? col_half : row_half);
  end
endmodule

// File: rtl/bank_map_decoder.sv
module bank_map_decoder
  import bmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  data_i,
  input  logic        bank_le_i,
  input  logic [15:0] addr_i,
  input  logic        dma_i,
  input  logic        dma_bank_we_i,
  input  logic        big_board_i,
  input  logic        row_1m_i,
  input  logic        rom_split_i,
  input  logic        mux_phase_i,
  output logic [2:0]  region_o,
  output logic        exp_ram_sel_o,
  output logic [1:0]  row_sel_o,
  output logic [9:0]  dram_addr_o
);
  localparam int unsigned LOG_S = 2;
  localparam int unsigned LOG_L = 4;

  logic [BANK_W-1:0] bank;
  region_e           region;
  logic [1:0]        row;
  logic [LOG_L-1:0]  off;
  logic              exp_en;

  bmd_bank_src #(.BANK_W(BANK_W)) u_src (
    .clk_i, .rst_ni, .data_i, .bank_le_i, .dma_i, .dma_bank_we_i,
    .bank_o(bank)
  );

  bmd_region_dec #(
    .BANK_W(BANK_W), .NUM_ROWS(4),
    .SMALL_ROW_BANKS(1 << LOG_S), .LARGE_ROW_BANKS(1 << LOG_L)
  ) u_dec (
    .bank_i(bank), .big_board_i, .row_1m_i, .rom_split_i,
    .region_o(region), .row_o(row), .off_o(off)
  );

  assign exp_en = (region == REG_EXP_RAM);

  bmd_addr_mux #(.ADDR_W(ADDR_W), .LOG_S(LOG_S), .LOG_L(LOG_L)) u_mux (
    .off_i(off), .addr_i, .row_1m_i, .phase_i(mux_phase_i), .en_i(exp_en),
    .dram_addr_o
  );

  assign region_o      = region;
  assign exp_ram_sel_o = exp_en;
  assign row_sel_o     = row;

  // R7
  unmapped_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_o != REG_EXP_RAM) |-> (!exp_ram_sel_o && row_sel_o == 2'd0 && dram_addr_o == 10'd0));
  // R8
  small_half_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp_ram_sel_o && !row_1m_i) |-> !dram_addr_o[9]);
  // R6
  rom_top_banks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_o == REG_EXP_ROM || region_o == REG_MB_ROM) |-> (bank[7:4] == 4'hF));
  // R2
  mb_ram_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_o == REG_MB_RAM) |-> (bank <= 8'h0F));
endmodule

// File: tb/bank_map_decoder_tb_top.sv
`timescale 1ns/1ps
module bank_map_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] data;
  logic bank_le, dma, dma_we, big, r1m, split, phase;
  logic [15:0] addr;
  logic [2:0] region;
  logic sel;
  logic [1:0] row;
  logic [9:0] dram;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bank_map_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .bank_le_i(bank_le), .addr_i(addr),
    .dma_i(dma), .dma_bank_we_i(dma_we), .big_board_i(big), .row_1m_i(r1m),
    .rom_split_i(split), .mux_phase_i(phase), .region_o(region), .exp_ram_sel_o(sel),
    .row_sel_o(row), .dram_addr_o(dram)
  );

  function automatic logic [7:0] f_base(logic b);
    return b ? 8'h10 : 8'h02;
  endfunction

  function automatic logic [2:0] f_region(logic [7:0] bk, logic b, logic m, logic s);
    logic [8:0] off;
    off = {1'b0, bk} - {1'b0, f_base(b)};
    if (bk < f_base(b)) return 3'd1;
    if (off < (m ? 9'd64 : 9'd16)) return 3'd2;
    if (bk == 8'hE0 || bk == 8'hE1) return 3'd3;
    if (bk >= (s ? 8'hFE : 8'hFC)) return 3'd5;
    if (bk >= 8'hF0) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [1:0] f_row(logic [7:0] bk, logic b, logic m);
    logic [7:0] off;
    off = bk - f_base(b);
    return m ? off[5:4] : off[3:2];
  endfunction

  function automatic logic [9:0] f_dram(logic [7:0] bk, logic [15:0] a, logic b, logic m, logic p);
    logic [7:0] off;
    logic [19:0] w;
    logic [17:0] n;
    off = bk - f_base(b);
    w = {off[3:0], a};
    n = {off[1:0], a};
    if (m) return p ? w[9:0] : w[19:10];
    return p ? {1'b0, n[8:0]} : {1'b0, n[17:9]};
  endfunction

  function automatic string f_tag(logic [2:0] rg, logic m);
    case (rg)
      3'd1: return "R2";
      3'd2: return m ? "R4" : "R3";
      3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  // full check of outputs for bank bk at current straps/addr/phase
  task automatic check_all(string pre, logic [7:0] bk);
    logic [2:0] er;
    string t;
    er = f_region(bk, big, r1m, split);
    t = (pre != "") ? pre : f_tag(er, r1m);
    check(t, "region", region, er);
    check(t, "sel", sel, er == 3'd2);
    check(t, "row", row, (er == 3'd2) ? f_row(bk, big, r1m) : 2'd0);
    check((er == 3'd2) ? (r1m ? "R9" : "R8") : "R7", "dram",
          dram, (er == 3'd2) ? f_dram(bk, addr, big, r1m, phase) : 10'd0);
  endtask

  task automatic cpu_cycle(logic [7:0] bk, logic [15:0] a);
    @(negedge clk);
    data = bk; bank_le = 1'b1; addr = a; phase = 1'b0;
    @(posedge clk); #1;
    bank_le = 1'b0;
    data = ~bk;  // R1: bus moves on, latched bank must stay
    #1;
    check_all("", bk);
    phase = 1'b1; #1;
    check_all("", bk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] edges [0:22];
    edges = '{8'h00, 8'h01, 8'h02, 8'h05, 8'h0E, 8'h0F, 8'h10, 8'h11, 8'h12, 8'h1F,
              8'h20, 8'h41, 8'h42, 8'h4F, 8'h50, 8'hDF, 8'hE0, 8'hE1, 8'hE2,
              8'hF0, 8'hFB, 8'hFC, 8'hFF};
    void'($urandom(32'd1234));
    data = 8'h5A; bank_le = 0; dma = 0; dma_we = 0; big = 0; r1m = 0; split = 0;
    phase = 0; addr = 16'h0000;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset leaves bank 0 -> motherboard RAM
    check("R1", "reset region", region, 3'd1);
    check("R1", "reset sel", sel, 0);
    check("R1", "reset dram", dram, 0);
    @(negedge clk); rst_n = 1'b1;

    // directed boundaries in all strap combinations
    for (int c = 0; c < 8; c++) begin
      big = c[0]; r1m = c[1]; split = c[2];
      foreach (edges[i]) cpu_cycle(edges[i], 16'hA5C3 ^ 16'(i * 16'h1111));
      cpu_cycle(8'hFD, 16'hFFFF);  // R6 split bank
      cpu_cycle(8'hFE, 16'h0001);
    end

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      big = r[0]; r1m = r[1]; split = r[2];
      cpu_cycle(r[3] ? 8'(r[15:8] % 8'h50) : r[15:8], r[31:16]);
    end

    // R10: DMA sourcing and bus bank hold
    big = 0; r1m = 1; split = 0;
    cpu_cycle(8'h03, 16'h1234);
    @(negedge clk);
    dma = 1; dma_we = 1; data = 8'h12; addr = 16'hBEEF; phase = 0;
    @(posedge clk); #1;
    dma_we = 0;
    check_all("R10", 8'h12);
    @(negedge clk);
    bank_le = 1; data = 8'hE0;  // ignored during DMA
    @(posedge clk); #1;
    bank_le = 0; data = 8'h77;
    #1;
    check_all("R10", 8'h12);
    phase = 1; #1;
    check_all("R10", 8'h12);
    @(negedge clk);
    dma = 0; addr = 16'h1234; phase = 0;
    #1;
    check_all("R10", 8'h03);
    // DMA bank write outside DMA, then a DMA cycle uses it
    @(negedge clk);
    dma_we = 1; data = 8'hFF;
    @(posedge clk); #1;
    dma_we = 0; data = 8'h00;
    check_all("R10", 8'h03);
    dma = 1; #1;
    check_all("R10", 8'hFF);
    @(negedge clk); dma = 0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule